// File: doc/BRIEF.md
# HDLC Transmitter with Modem Handshake

This block turns a stream of frame bytes into a bit-serial HDLC line signal, one bit per period of an external 1x transmit clock. Bytes arrive over a valid/ready/last interface. Each frame goes out between two 0x7E flags. A zero is stuffed after every run of five ones in the payload and FCS. A complemented CRC-16 closes the frame. When nothing is queued, the line idles at continuous ones. If the byte source stops in the middle of a frame, an abort of seven ones is sent.

A static mode input selects how two modem pins behave. In half-duplex mode, the request output is raised while a frame is pending or on the wire. While the clear input is high, the line is held at ones and no transmission begins. In full-duplex mode, the same two pins are plain general-purpose bits: a registered copy of an output control input, and a registered copy of the clear input.

All state changes on the falling edge of the transmit clock. As a result, the serial output changes only on that edge.

Top module: `hdlc_tx_modem`

## Requirements
- R1: After reset, and whenever no frame is pending, `td_o` is 1 and `tx_ready_o` is 0.
- R2: Every frame starts and ends with the pattern 0x7E, sent least significant bit first and without zero stuffing. Back-to-back frames each carry their own opening and closing flags.
- R3: Payload bytes go out least significant bit first. After five consecutive ones in the payload or FCS, a single 0 is inserted, including just before the closing flag.
- R4: Right after the last byte, the FCS is sent. It is the reflected CRC-16 (feedback constant 0x8408, polynomial x^16+x^12+x^5+1) over all payload bits, preset to 0xFFFF. It is sent complemented, least significant bit first, and stuffed per R3.
- R5: `td_o` changes only on the falling edge of `clk_i`.
- R6: With `half_dup_i`=1, `rts_o` is 1 from the cycle a byte is offered on an idle line until the last bit of the closing flag has been sent. After that, it is 0 if nothing is offered.
- R7: With `half_dup_i`=1 and `cts_i`=1, `td_o` is 1 after the next falling edge and `tx_ready_o` is 0. A pending frame starts only once `cts_i` is 0.
- R8: With `half_dup_i`=0, `rts_o` equals `gp_out_i` as sampled at the previous falling edge. `gp_in_o` equals `cts_i` as sampled at the previous falling edge, and `cts_i` does not hold off transmission. With `half_dup_i`=1, `gp_in_o` is 0.
- R9: If no byte is valid when the next payload byte is needed, seven ones follow the last payload bit. The transmitter then returns to idle and accepts a new frame.
- R10: Asserting `rst_ni` low stops a frame in progress at once, forcing `td_o` to 1 and `tx_ready_o` to 0. The line then stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 1x transmit bit clock; logic updates on its falling edge |
| rst_ni | input | 1 | Active-low asynchronous reset |
| half_dup_i | input | 1 | 1 = modem handshake mode, 0 = general-purpose pin mode |
| tx_data_i | input | 8 | Frame byte |
| tx_valid_i | input | 1 | Frame byte is valid |
| tx_last_i | input | 1 | Byte is the final byte of the frame |
| tx_ready_o | output | 1 | Byte is taken at the coming falling edge |
| td_o | output | 1 | Serial line output |
| rts_o | output | 1 | Request output or general-purpose output bit |
| cts_i | input | 1 | Clear input or general-purpose input bit |
| gp_out_i | input | 1 | Value for `rts_o` in general-purpose mode |
| gp_in_o | output | 1 | Registered `cts_i` in general-purpose mode |

## Verification
A scoreboard predicts every frame bit by bit and compares it with the line: flags, stuffed payload, FCS, and any abort. The frames are chosen to cover different behaviour:
- short mixed payloads check bit order and the CRC;
- runs of 0xFF bytes, and a payload byte equal to the flag pattern, force stuffing in payload and FCS, and show flags are never stuffed;
- back-to-back frames show the flag pairing;
- a dropped source shows the abort.

Holding the clear input high before a frame separates the two pin modes: half duplex must hold the line at ones with the request raised, while full duplex must send the frame. A reset in mid-frame checks recovery.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPEN, ST_DATA, ST_FCS, ST_CLOSE, ST_ABORT
  } tx_state_e;

  localparam logic [7:0]  FLAG_BYTE     = 8'h7E;
  localparam logic [15:0] CRC_POLY_REFL = 16'h8408;
endpackage

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16 #(
  parameter int          FCS_W = 16,
  parameter logic [FCS_W-1:0] POLY = hdlc_tx_pkg::CRC_POLY_REFL
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             init_i,
  input  logic             en_i,
  input  logic             bit_i,
  output logic [FCS_W-1:0] crc_next_o
);
  logic [FCS_W-1:0] crc_q;

  // reflected shift: feedback taken from the low end
  assign crc_next_o = (crc_q[0] ^ bit_i) ? ((crc_q >> 1) ^ POLY) : (crc_q >> 1);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     crc_q <= '1;
    else if (init_i) crc_q <= '1;
    else if (en_i)   crc_q <= crc_next_o;
  end
endmodule

// File: rtl/hdlc_tx_framer.sv
module hdlc_tx_framer import hdlc_tx_pkg::*; #(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stall_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              td_o,
  output logic              busy_o
);
  localparam int SH_W  = FCS_W;
  localparam int CNT_W = $clog2(FCS_W);
  localparam int RUN_W = $clog2(STUFF_RUN + 1);

  tx_state_e        state_q;
  logic [SH_W-1:0]  sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RUN_W-1:0] run_q;
  logic             last_q, td_q, busy_q;
  logic             stuff_now, advance, byte_end, fcs_end, fcs_init, fcs_en;
  logic [FCS_W-1:0] crc_next;

  assign stuff_now = (run_q == RUN_W'(STUFF_RUN)) &&
                     (state_q == ST_DATA || state_q == ST_FCS ||
                      (state_q == ST_CLOSE && cnt_q == '0));
  assign advance   = !stall_i && !stuff_now;
  assign byte_end  = cnt_q == CNT_W'(DATA_W - 1);
  assign fcs_end   = cnt_q == CNT_W'(FCS_W - 1);
  assign ready_o   = advance && byte_end &&
                     (state_q == ST_OPEN || (state_q == ST_DATA && !last_q));
  assign fcs_init  = !stall_i && state_q == ST_IDLE && valid_i;
  assign fcs_en    = advance && state_q == ST_DATA;
  assign td_o      = td_q;
  assign busy_o    = busy_q;

  hdlc_fcs16 #(.FCS_W(FCS_W)) u_fcs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .init_i     (fcs_init),
    .en_i       (fcs_en),
    .bit_i      (sh_q[0]),
    .crc_next_o (crc_next)
  );

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sh_q    <= '0;
      cnt_q   <= '0;
      run_q   <= '0;
      last_q  <= 1'b0;
      td_q    <= 1'b1;
      busy_q  <= 1'b0;
    end else if (stall_i) begin
      td_q <= 1'b1;                       // line held at ones, state frozen
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          td_q   <= 1'b1;
          busy_q <= 1'b0;
          run_q  <= '0;
          cnt_q  <= '0;
          if (valid_i) begin
            state_q <= ST_OPEN;
            sh_q    <= SH_W'(FLAG_BYTE);
          end
        end
        ST_OPEN: begin
          td_q   <= sh_q[0];
          busy_q <= 1'b1;
          sh_q   <= sh_q >> 1;
          cnt_q  <= cnt_q + 1'b1;
          if (byte_end) begin
            cnt_q <= '0;
            run_q <= '0;
            if (valid_i) begin
              sh_q    <= SH_W'(data_i);
              last_q  <= last_i;
              state_q <= ST_DATA;
            end else begin
              state_q <= ST_ABORT;
            end
          end
        end
        ST_DATA, ST_FCS: begin
          if (stuff_now) begin
            td_q  <= 1'b0;
            run_q <= '0;
          end else begin
            td_q  <= sh_q[0];
            run_q <= sh_q[0] ? run_q + RUN_W'(1) : '0;
            sh_q  <= sh_q >> 1;
            cnt_q <= cnt_q + 1'b1;
            if (state_q == ST_DATA && byte_end) begin
              cnt_q <= '0;
              if (last_q) begin
                sh_q    <= ~crc_next;     // includes the bit sent now
                state_q <= ST_FCS;
              end else if (valid_i) begin
                sh_q   <= SH_W'(data_i);
                last_q <= last_i;
              end else begin
                state_q <= ST_ABORT;
              end
            end else if (state_q == ST_FCS && fcs_end) begin
              cnt_q   <= '0;
              sh_q    <= SH_W'(FLAG_BYTE);
              state_q <= ST_CLOSE;
            end
          end
        end
        ST_CLOSE: begin
          if (stuff_now) begin
            td_q  <= 1'b0;
            run_q <= '0;
          end else begin
            td_q  <= sh_q[0];
            sh_q  <= sh_q >> 1;
            run_q <= '0;
            cnt_q <= cnt_q + 1'b1;
            if (byte_end) begin
              cnt_q   <= '0;
              state_q <= ST_IDLE;
            end
          end
        end
        ST_ABORT: begin
          td_q  <= 1'b1;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == CNT_W'(ABORT_LEN - 1)) begin
            cnt_q   <= '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3
  stuff_limit_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_W'(STUFF_RUN));
  // R3
  stuff_zero_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (stuff_now && !stall_i) |=> !td_o);
  // R9
  abort_ones_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (state_q == ST_ABORT) |=> td_o);
endmodule

// File: rtl/hdlc_modem_io.sv
module hdlc_modem_io (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  input  logic busy_i,
  input  logic pending_i,
  input  logic gp_out_i,
  input  logic cts_i,
  output logic rts_o,
  output logic gp_in_o,
  output logic stall_o
);
  logic gp_out_q, gp_in_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gp_out_q <= 1'b0;
      gp_in_q  <= 1'b0;
    end else begin
      gp_out_q <= gp_out_i;
      gp_in_q  <= !half_i && cts_i;
    end
  end

  assign rts_o   = half_i ? (busy_i || pending_i) : gp_out_q;
  assign gp_in_o = gp_in_q;
  assign stall_o = half_i && cts_i;

  // R8
  gpio_out_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    !half_i |=> (half_i || rts_o == $past(gp_out_i)));
  // R8
  gpin_half_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    half_i |=> !gp_in_o);
endmodule

// File: rtl/hdlc_tx_modem.sv
module hdlc_tx_modem #(
  parameter int DATA_W    = 8,
  parameter int FCS_W     = 16,
  parameter int STUFF_RUN = 5,
  parameter int ABORT_LEN = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              half_dup_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  input  logic              tx_last_i,
  output logic              tx_ready_o,
  output logic              td_o,
  output logic              rts_o,
  input  logic              cts_i,
  input  logic              gp_out_i,
  output logic              gp_in_o
);
  logic stall, busy;

  hdlc_modem_io u_io (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .half_i    (half_dup_i),
    .busy_i    (busy),
    .pending_i (tx_valid_i),
    .gp_out_i  (gp_out_i),
    .cts_i     (cts_i),
    .rts_o     (rts_o),
    .gp_in_o   (gp_in_o),
    .stall_o   (stall)
  );

  hdlc_tx_framer #(
    .DATA_W(DATA_W), .FCS_W(FCS_W), .STUFF_RUN(STUFF_RUN), .ABORT_LEN(ABORT_LEN)
  ) u_framer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stall_i (stall),
    .data_i  (tx_data_i),
    .valid_i (tx_valid_i),
    .last_i  (tx_last_i),
    .ready_o (tx_ready_o),
    .td_o    (td_o),
    .busy_o  (busy)
  );

  // R7
  cts_hold_ones_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (half_dup_i && cts_i) |=> td_o);
  // R7
  cts_no_accept_chk: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (half_dup_i && cts_i) |-> !tx_ready_o);
endmodule

// File: tb/tb_hdlc_tx_modem.sv
module tb_hdlc_tx_modem;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0, half = 1'b1, valid = 1'b0, last = 1'b0;
  logic cts = 1'b0, gp_out = 1'b0;
  logic [7:0] data = '0;
  logic ready, td, rts, gp_in;

  int checks = 0, fails = 0;
  int pushed = 0, frames_done = 0;
  int b_run, b_len;
  bit exp_bits_q[$];
  int exp_len_q[$];
  logic [7:0] fb [0:15];

  hdlc_tx_modem dut (
    .clk_i(clk), .rst_ni(rst_ni), .half_dup_i(half),
    .tx_data_i(data), .tx_valid_i(valid), .tx_last_i(last), .tx_ready_o(ready),
    .td_o(td), .rts_o(rts), .cts_i(cts), .gp_out_i(gp_out), .gp_in_o(gp_in)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic add_raw(input bit b);
    exp_bits_q.push_back(b);
    b_len++;
  endtask

  task automatic add_stuffed(input bit b);
    if (b_run == 5) begin add_raw(1'b0); b_run = 0; end
    add_raw(b);
    b_run = b ? b_run + 1 : 0;
  endtask

  // driver: predicts the line bits of the frame, then hands bytes over
  task automatic send_frame(input int n, input bit abort_it, input bit wait_end);
    logic [15:0] c = 16'hFFFF;
    logic [15:0] fcs;
    logic [7:0] flag = 8'h7E;
    int target;
    b_run = 0; b_len = 0;
    for (int k = 0; k < 8; k++) add_raw(flag[k]);
    for (int i = 0; i < n; i++)
      for (int k = 0; k < 8; k++) begin
        add_stuffed(fb[i][k]);
        c = (c[0] ^ fb[i][k]) ? ((c >> 1) ^ 16'h8408) : (c >> 1);
      end
    if (abort_it) begin
      for (int k = 0; k < 7; k++) add_raw(1'b1);
    end else begin
      fcs = ~c;
      for (int k = 0; k < 16; k++) add_stuffed(fcs[k]);
      if (b_run == 5) add_raw(1'b0);
      for (int k = 0; k < 8; k++) add_raw(flag[k]);
    end
    exp_len_q.push_back(b_len);
    pushed++;
    target = pushed;
    for (int i = 0; i < n; i++) begin
      bit done = 1'b0;
      data  = fb[i];
      last  = (i == n - 1) && !abort_it;
      valid = 1'b1;
      while (!done) begin
        #1;
        done = ready;
        @(posedge clk);
      end
    end
    valid = 1'b0;
    last  = 1'b0;
    if (wait_end) begin
      wait (frames_done >= target);
      @(posedge clk);
    end
  endtask

  // monitor: pops predicted bits and compares with the line
  initial forever begin
    int n, errs, rts_errs, edge_errs;
    bit b, e;
    wait (exp_len_q.size() > 0);
    @(posedge clk);
    while (td !== 1'b0) @(posedge clk);
    n = exp_len_q.pop_front();
    errs = 0; rts_errs = 0; edge_errs = 0;
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(posedge clk);
      b = td;
      e = exp_bits_q.pop_front();
      if (b !== e) errs++;
      if (half && rts !== 1'b1) rts_errs++;
      #(CLK_PERIOD/2 - 1);
      if (td !== b) edge_errs++;
    end
    check(errs == 0, "R2_R3_R4", "frame bit mismatches", errs, 0);
    check(edge_errs == 0, "R5", "td moved before falling edge", edge_errs, 0);
    if (half) check(rts_errs == 0, "R6", "rts low during frame", rts_errs, 0);
    @(posedge clk);
    if (half && !valid) check(rts == 1'b0, "R6", "rts after frame", rts, 0);
    frames_done++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int bad;
    repeat (3) @(posedge clk);
    // R1 R10 reset state
    check(td == 1'b1, "R10", "td in reset", td, 1);
    check(ready == 1'b0, "R10", "ready in reset", ready, 0);
    rst_ni = 1'b1;
    bad = 0;
    repeat (10) begin @(posedge clk); if (td !== 1'b1 || ready !== 1'b0) bad++; end
    check(bad == 0, "R1", "idle line not ones", bad, 0);
    check(rts == 1'b0, "R6", "rts idle", rts, 0);

    // R2 R4 short mixed frame
    fb[0] = 8'h01; fb[1] = 8'hA2; fb[2] = 8'h3C;
    send_frame(3, 1'b0, 1'b1);
    // R3 stuffing across ones runs and a flag-valued byte
    fb[0] = 8'hFF; fb[1] = 8'hFF; fb[2] = 8'h7E; fb[3] = 8'hFF;
    send_frame(4, 1'b0, 1'b1);
    // single byte frame
    fb[0] = 8'h00;
    send_frame(1, 1'b0, 1'b1);
    // R2 back-to-back frames
    fb[0] = 8'h5A; fb[1] = 8'hC3;
    send_frame(2, 1'b0, 1'b0);
    fb[0] = 8'hF0;
    send_frame(1, 1'b0, 1'b1);

    // R7 clear input holds the line in half duplex
    cts = 1'b1;
    fb[0] = 8'h3C; fb[1] = 8'h5A;
    fork
      send_frame(2, 1'b0, 1'b1);
      begin
        @(posedge clk);
        bad = 0;
        repeat (16) begin
          @(posedge clk);
          if (td !== 1'b1 || ready !== 1'b0 || rts !== 1'b1) bad++;
        end
        check(bad == 0, "R7", "cts high: td/ready/rts wrong cycles", bad, 0);
        check(gp_in == 1'b0, "R8", "gp_in in half duplex", gp_in, 0);
        cts = 1'b0;
      end
    join

    // R9 source runs dry mid-frame
    fb[0] = 8'hAA; fb[1] = 8'hFF;
    send_frame(2, 1'b1, 1'b1);
    check(td == 1'b1 && ready == 1'b0, "R9", "idle after abort", {td, ready}, 2);
    fb[0] = 8'h81;
    send_frame(1, 1'b0, 1'b1);

    // R8 general-purpose pins in full duplex
    half = 1'b0;
    gp_out = 1'b1;
    @(posedge clk);
    check(rts == 1'b1, "R8", "rts follows gp_out high", rts, 1);
    gp_out = 1'b0;
    @(posedge clk);
    check(rts == 1'b0, "R8", "rts follows gp_out low", rts, 0);
    cts = 1'b1;
    @(posedge clk);
    check(gp_in == 1'b1, "R8", "gp_in follows cts", gp_in, 1);
    fb[0] = 8'h12; fb[1] = 8'hF8;
    send_frame(2, 1'b0, 1'b1);   // R8 cts does not gate full duplex
    cts = 1'b0;
    @(posedge clk);
    check(gp_in == 1'b0, "R8", "gp_in follows cts low", gp_in, 0);
    half = 1'b1;

    // R10 reset in mid-frame
    data = 8'h81; last = 1'b0; valid = 1'b1;
    repeat (14) @(posedge clk);
    #2 rst_ni = 1'b0;
    #1;
    check(td == 1'b1, "R10", "td after mid-frame reset", td, 1);
    check(ready == 1'b0, "R10", "ready after mid-frame reset", ready, 0);
    valid = 1'b0;
    #1;
    check(rts == 1'b0, "R10", "rts after reset, nothing pending", rts, 0);
    @(posedge clk);
    rst_ni = 1'b1;
    bad = 0;
    repeat (20) begin @(posedge clk); if (td !== 1'b1) bad++; end
    check(bad == 0, "R10", "line not idle after reset", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule